// File: doc/BRIEF.md
# PAM-4 Driver Code Generator

This block is the digital control front end of a four-level pulse-amplitude test driver. Each reference clock cycle it takes one parallel word of 2-bit symbols, from an external pattern input or from an internal seedable PRBS-7 generator. It turns every symbol slot into a three-bit thermometer word for the three amplitude segments of the analog output stage, and raises a separate offset enable while the driver is on. Slot 0 leaves the word first when the analog side serialises it.

Alongside the symbol path, the block holds a lower and an upper current-DAC code for each of the four output levels on each leg of the differential output. The four levels are programmed independently, so the spacing between them can be unequal. The codes for the whole reference cycle come from one modulation mode: none, two-state toggling between the limits, or a triangular sweep across the limit range. A relation setting chooses how the negative leg follows the positive leg: in phase, in opposite phase, or stepped at random. This produces common-mode, normal-mode or random voltage-noise stimulus for receiver tolerance tests.

Top module: `pam4_code_gen`

## Requirements
- R1: While reset is asserted, `seg_en`, `ofs_en`, `dac_p` and `dac_n` are all zero.
- R2: One clock after a word is presented, slot i (bits 2i+1:2i of the word) appears on `seg_en[3i+2:3i]` as 00→000, 01→001, 10→011, 11→111, with `ofs_en` at 1. When `drv_en` was 0, `seg_en` and `ofs_en` are 0.
- R3: A write with `cfg_we` stores `cfg_wdata` into the limit selected by `cfg_addr`: bit 3 picks the leg (0 positive, 1 negative), bits 2:1 the level, bit 0 the bound (0 lower, 1 upper). With `mode_sel`=0 (off), each level's field `[k*CW +: CW]` on each leg shows its own lower limit.
- R4: With `mode_sel`=1 (two-state), the clock that applies the mode shows every lower limit, and each later clock swaps between the upper and lower limits.
- R5: With `mode_sel`=2 (sweep), each code starts at its lower limit and moves by one per clock up to the upper limit, then back down, reversing at each limit. When both limits are equal, the code stays constant.
- R6: With `rel_sel`=0 (common), the negative leg is in the same phase as the positive leg.
- R7: With `rel_sel`=1 (normal), the negative leg starts at its upper limit and moves opposite to the positive leg.
- R8: With `rel_sel`=2 (independent), the positive leg steps every clock and the negative leg steps only on clocks where bit 0 of the PRBS state is 1.
- R9: With `src_sel`=1, the word is produced by the PRBS x^7+x^6+1 (feedback = s[6]^s[5], shifted in at bit 0). The generator runs 16 steps per clock, and word bit j is the j-th feedback bit. The reset state is 7'h7F, and `prbs_load` loads `prbs_seed` on the next clock.
- R10: A zero seed loads 7'h01 instead, so the PRBS state is never zero.
- R11: Any change of `mode_sel` or `rel_sel` restarts the modulation sequence on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Driver enable for segments and offset |
| src_sel | input | 1 | Symbol source: 0 external, 1 PRBS |
| sym_in | input | 2*SYMS | External symbol word, slot i at bits 2i+1:2i |
| prbs_load | input | 1 | Load PRBS seed |
| prbs_seed | input | 7 | PRBS seed value |
| mode_sel | input | 2 | Modulation: 0 off, 1 two-state, 2 sweep |
| rel_sel | input | 2 | Leg relation: 0 common, 1 normal, 2 independent |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_addr | input | 4 | Limit register address {leg, level, bound} |
| cfg_wdata | input | CW | Limit register write data |
| seg_en | output | 3*SYMS | Thermometer segment enables per slot |
| ofs_en | output | 1 | Offset enable |
| dac_p | output | 4*CW | Positive-leg DAC codes, level k at [k*CW +: CW] |
| dac_n | output | 4*CW | Negative-leg DAC codes, level k at [k*CW +: CW] |

## Verification
The bench uses the default values SYMS=8 and CW=6. Eight slots give all four symbol values several slot positions in one word, and the PRBS word is a full 16 bits. Six-bit codes let the sweep test place limits at the top of the code range (60 to 63), where the counter turns around, while staying small enough to cover a full up-and-down cycle in a few clocks. The bench keeps its own model of the PRBS state. This lets it predict the random steps of the negative leg in independent mode, as well as the generated words after a seed load.

// File: rtl/pam4_pkg.sv
package pam4_pkg;
    localparam int LEVELS = 4;
    localparam int LEGS   = 2;
    localparam int SEG_W  = 3;
    localparam int PRBS_W = 7;

    typedef enum logic [1:0] {
        MOD_OFF   = 2'd0,
        MOD_BIN   = 2'd1,
        MOD_SWEEP = 2'd2,
        MOD_RSVD  = 2'd3
    } mod_e;

    typedef enum logic [1:0] {
        REL_COMMON = 2'd0,
        REL_NORMAL = 2'd1,
        REL_INDEP  = 2'd2,
        REL_RSVD   = 2'd3
    } rel_e;
endpackage

// File: rtl/pam4_prbs.sv
module pam4_prbs
    import pam4_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PRBS_W-1:0] seed,
    output logic [STEPS-1:0]  word,
    output logic [PRBS_W-1:0] state
);
    typedef struct packed {
        logic [PRBS_W-1:0] s;
    } prbs_s;

    prbs_s st_d, st_q;

    always_comb begin
        logic [PRBS_W-1:0] w;
        logic              fb;
        w    = st_q.s;
        word = '0;
        for (int j = 0; j < STEPS; j++) begin
            fb      = w[6] ^ w[5];
            word[j] = fb;
            w       = {w[5:0], fb};
        end
        st_d = st_q;
        if (load) begin
            st_d.s = (seed == '0) ? PRBS_W'(1) : seed;
        end else begin
            st_d.s = w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s: '1};
        else        st_q <= st_d;
    end

    assign state = st_q.s;
endmodule

// File: rtl/pam4_therm_lane.sv
module pam4_therm_lane
    import pam4_pkg::*;
#(
    parameter int SYMS = 8
) (
    input  logic [2*SYMS-1:0]     word,
    input  logic                  en,
    output logic [SEG_W*SYMS-1:0] seg
);
    for (genvar i = 0; i < SYMS; i++) begin : g_slot
        logic [1:0]       sym;
        logic [SEG_W-1:0] code;
        assign sym = word[2*i +: 2];
        always_comb begin
            case (sym)
                2'b00:   code = 3'b000;
                2'b01:   code = 3'b001;
                2'b10:   code = 3'b011;
                default: code = 3'b111;
            endcase
        end
        assign seg[SEG_W*i +: SEG_W] = en ? code : '0;
    end
endmodule

// File: rtl/pam4_lvl_mod.sv
module pam4_lvl_mod
    import pam4_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          start_hi,
    input  logic          step_en,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] code
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
        logic          tgl;
    } lvl_s;

    lvl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.tgl = start_hi;
            st_d.cnt = start_hi ? hi : lo;
            st_d.up  = !start_hi;
        end else if (step_en) begin
            st_d.tgl = !st_q.tgl;
            if (mode == MOD_SWEEP) begin
                if (st_q.up) begin
                    if (st_q.cnt < hi) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end else begin
                        st_d.up  = 1'b0;
                        st_d.cnt = (st_q.cnt > lo) ? st_q.cnt - 1'b1 : st_q.cnt;
                    end
                end else begin
                    if (st_q.cnt > lo) begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end else begin
                        st_d.up  = 1'b1;
                        st_d.cnt = (st_q.cnt < hi) ? st_q.cnt + 1'b1 : st_q.cnt;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, up: 1'b1, tgl: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (mode)
            MOD_BIN:   code = st_q.tgl ? hi : lo;
            MOD_SWEEP: code = st_q.cnt;
            default:   code = lo;
        endcase
    end
endmodule

// File: rtl/pam4_code_gen.sv
module pam4_code_gen
    import pam4_pkg::*;
#(
    parameter int SYMS = 8,
    parameter int CW   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  drv_en,
    input  logic                  src_sel,
    input  logic [2*SYMS-1:0]     sym_in,
    input  logic                  prbs_load,
    input  logic [PRBS_W-1:0]     prbs_seed,
    input  logic [1:0]            mode_sel,
    input  logic [1:0]            rel_sel,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [CW-1:0]         cfg_wdata,
    output logic [SEG_W*SYMS-1:0] seg_en,
    output logic                  ofs_en,
    output logic [LEVELS*CW-1:0]  dac_p,
    output logic [LEVELS*CW-1:0]  dac_n
);
    localparam int WORD_W = 2 * SYMS;
    localparam int SEG_BITS = SEG_W * SYMS;

    typedef struct packed {
        logic [1:0]                              mode;
        logic [1:0]                              rel;
        logic [LEGS-1:0][LEVELS-1:0][1:0][CW-1:0] lim;
        logic [SEG_BITS-1:0]                     seg;
        logic                                    ofs;
    } top_s;

    top_s st_d, st_q;

    logic [WORD_W-1:0]   prbs_word;
    logic [PRBS_W-1:0]   prbs_cur;
    logic [WORD_W-1:0]   word_sel;
    logic [SEG_BITS-1:0] seg_c;
    logic                restart;
    logic [1:0]          mode_cur;

    pam4_prbs #(.STEPS(WORD_W)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (prbs_load),
        .seed  (prbs_seed),
        .word  (prbs_word),
        .state (prbs_cur)
    );

    assign word_sel = src_sel ? prbs_word : sym_in;

    pam4_therm_lane #(.SYMS(SYMS)) u_lane (
        .word (word_sel),
        .en   (drv_en),
        .seg  (seg_c)
    );

    assign restart  = (mode_sel != st_q.mode) || (rel_sel != st_q.rel);
    assign mode_cur = st_q.mode;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_sel;
        st_d.rel  = rel_sel;
        st_d.seg  = seg_c;
        st_d.ofs  = drv_en;
        if (cfg_we) begin
            st_d.lim[cfg_addr[3]][cfg_addr[2:1]][cfg_addr[0]] = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_en = st_q.seg;
    assign ofs_en = st_q.ofs;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic step_en;
        logic start_hi;
        logic [LEVELS*CW-1:0] codes;
        if (g == 0) begin : g_pos
            assign step_en  = 1'b1;
            assign start_hi = 1'b0;
        end else begin : g_neg
            assign step_en  = (st_q.rel == REL_INDEP) ? prbs_cur[0] : 1'b1;
            assign start_hi = (rel_sel == REL_NORMAL);
        end
        for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
            pam4_lvl_mod #(.CW(CW)) u_mod (
                .clk      (clk),
                .rst_n    (rst_n),
                .restart  (restart),
                .start_hi (start_hi),
                .step_en  (step_en),
                .mode     (st_q.mode),
                .lo       (st_q.lim[g][k][0]),
                .hi       (st_q.lim[g][k][1]),
                .code     (codes[k*CW +: CW])
            );
        end
    end

    assign dac_p = g_leg[0].codes;
    assign dac_n = g_leg[1].codes;
endmodule

module pam4_code_gen_chk
    import pam4_pkg::*;
#(
    parameter int SYMS = 8,
    parameter int CW   = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  drv_en,
    input logic [SEG_W*SYMS-1:0] seg_en,
    input logic                  ofs_en,
    input logic [PRBS_W-1:0]     prbs_cur,
    input logic [1:0]            mode_cur,
    input logic                  restart,
    input logic [CW-1:0]         dac_p0
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic therm_ok(input logic [SEG_W*SYMS-1:0] s);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < SYMS; i++) begin
            if (s[SEG_W*i+1] && !s[SEG_W*i])   ok = 1'b0;
            if (s[SEG_W*i+2] && !s[SEG_W*i+1]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R2
    seg_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_ok(seg_en));

    // R2
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (seg_en == '0 && !ofs_en));

    // R2
    ofs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |=> ofs_en);

    // R10
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_cur != '0);

    // R5
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_cur == MOD_SWEEP && $past(mode_cur) == MOD_SWEEP && !$past(restart))
        |-> (dac_p0 == $past(dac_p0) || dac_p0 == $past(dac_p0) + 1'b1 ||
             dac_p0 == $past(dac_p0) - 1'b1));
endmodule

bind pam4_code_gen pam4_code_gen_chk #(.SYMS(SYMS), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_en   (drv_en),
    .seg_en   (seg_en),
    .ofs_en   (ofs_en),
    .prbs_cur (prbs_cur),
    .mode_cur (mode_cur),
    .restart  (restart),
    .dac_p0   (dac_p[CW-1:0])
);

// File: tb/pam4_code_gen_tb.sv
module pam4_code_gen_tb;
    localparam int SYMS = 8;
    localparam int CW   = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 drv_en = 1'b0;
    logic                 src_sel = 1'b0;
    logic [2*SYMS-1:0]    sym_in = '0;
    logic                 prbs_load = 1'b0;
    logic [6:0]           prbs_seed = '0;
    logic [1:0]           mode_sel = 2'd0;
    logic [1:0]           rel_sel = 2'd0;
    logic                 cfg_we = 1'b0;
    logic [3:0]           cfg_addr = '0;
    logic [CW-1:0]        cfg_wdata = '0;
    logic [3*SYMS-1:0]    seg_en;
    logic                 ofs_en;
    logic [4*CW-1:0]      dac_p;
    logic [4*CW-1:0]      dac_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int lo_v [2][4];
    int hi_v [2][4];
    logic [6:0] m_prbs;

    always #2 clk = ~clk;

    pam4_code_gen #(.SYMS(SYMS), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .src_sel(src_sel),
        .sym_in(sym_in), .prbs_load(prbs_load), .prbs_seed(prbs_seed),
        .mode_sel(mode_sel), .rel_sel(rel_sel), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .seg_en(seg_en),
        .ofs_en(ofs_en), .dac_p(dac_p), .dac_n(dac_n)
    );

    function automatic logic [22:0] b_adv(input logic [6:0] s0);
        logic [6:0]  s;
        logic [15:0] w;
        logic        fb;
        s = s0;
        for (int j = 0; j < 16; j++) begin
            fb   = s[6] ^ s[5];
            w[j] = fb;
            s    = {s[5:0], fb};
        end
        return {s, w};
    endfunction

    function automatic logic [3*SYMS-1:0] b_seg(input logic [2*SYMS-1:0] w);
        logic [3*SYMS-1:0] r;
        for (int i = 0; i < SYMS; i++) begin
            case (w[2*i +: 2])
                2'd0: r[3*i +: 3] = 3'b000;
                2'd1: r[3*i +: 3] = 3'b001;
                2'd2: r[3*i +: 3] = 3'b011;
                default: r[3*i +: 3] = 3'b111;
            endcase
        end
        return r;
    endfunction

    // bench-side PRBS state model (R9, R10)
    always @(posedge clk) begin
        if (!rst_n)          m_prbs <= 7'h7F;
        else if (prbs_load)  m_prbs <= (prbs_seed == 0) ? 7'h01 : prbs_seed;
        else                 m_prbs <= b_adv(m_prbs)[22:16];
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int leg, input int lvl, input int bound, input int val);
        cfg_we    = 1'b1;
        cfg_addr  = 4'((leg << 3) | (lvl << 1) | bound);
        cfg_wdata = CW'(val);
        if (bound == 0) lo_v[leg][lvl] = val;
        else            hi_v[leg][lvl] = val;
        tick();
        cfg_we = 1'b0;
    endtask

    // phase 0 = lower, 1 = upper for all levels of one leg
    function automatic logic [4*CW-1:0] leg_vec(input int leg, input bit ph);
        logic [4*CW-1:0] v;
        for (int k = 0; k < 4; k++)
            v[k*CW +: CW] = CW'(ph ? hi_v[leg][k] : lo_v[leg][k]);
        return v;
    endfunction

    task automatic t_reset();
        #3;
        check("R1 seg", 64'(seg_en), 0);
        check("R1 ofs", 64'(ofs_en), 0);
        check("R1 dac", 64'({dac_p, dac_n}), 0);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_ext_therm();
        logic [15:0] pats [2];
        pats[0] = 16'b00_01_10_11_11_10_01_00;
        pats[1] = 16'hE41B;
        drv_en = 1'b1;
        src_sel = 1'b0;
        foreach (pats[p]) begin
            sym_in = pats[p];
            tick();
            check("R2 therm", 64'(seg_en), 64'(b_seg(pats[p])));
            check("R2 ofs on", 64'(ofs_en), 1);
        end
    endtask

    task automatic t_drv_off();
        sym_in = 16'hFFFF;
        drv_en = 1'b0;
        tick();
        check("R2 drv off seg", 64'(seg_en), 0);
        check("R2 drv off ofs", 64'(ofs_en), 0);
        drv_en = 1'b1;
    endtask

    task automatic t_limits();
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < 4; k++) begin
                wr(g, k, 0, 4 + k * 10 + g * 3);
                wr(g, k, 1, 9 + k * 10 + g * 3);
            end
        tick();
        check("R3 off p", 64'(dac_p), 64'(leg_vec(0, 0)));
        check("R3 off n", 64'(dac_n), 64'(leg_vec(1, 0)));
    endtask

    task automatic t_binary_common();
        mode_sel = 2'd1;
        rel_sel  = 2'd0;
        tick();
        for (int c = 0; c < 6; c++) begin
            check("R4 bin p", 64'(dac_p), 64'(leg_vec(0, c[0])));
            check("R6 common n", 64'(dac_n), 64'(leg_vec(1, c[0])));
            tick();
        end
    endtask

    task automatic t_normal();
        rel_sel = 2'd1;
        tick();
        for (int c = 0; c < 5; c++) begin
            check("R7 normal p", 64'(dac_p), 64'(leg_vec(0, c[0])));
            check("R7 normal n", 64'(dac_n), 64'(leg_vec(1, !c[0])));
            tick();
        end
    endtask

    task automatic t_indep();
        bit tn = 1'b0;
        bit rb;
        rel_sel = 2'd2;
        tick();
        check("R11 restart on rel change", 64'(dac_n), 64'(leg_vec(1, 0)));
        for (int c = 0; c < 16; c++) begin
            check("R8 indep n", 64'(dac_n), 64'(leg_vec(1, tn)));
            check("R8 indep p", 64'(dac_p), 64'(leg_vec(0, c[0])));
            rb = m_prbs[0];
            tick();
            if (rb) tn = !tn;
        end
    endtask

    task automatic t_sweep();
        int e0 = 60;
        bit up = 1'b1;
        rel_sel = 2'd0;
        mode_sel = 2'd0;
        wr(0, 0, 0, 60);
        wr(0, 0, 1, 63);
        wr(0, 1, 0, 7);
        wr(0, 1, 1, 7);
        mode_sel = 2'd2;
        tick();
        for (int c = 0; c < 10; c++) begin
            check("R5 sweep lvl0", 64'(dac_p[CW-1:0]), 64'(e0));
            check("R5 sweep flat lvl1", 64'(dac_p[CW +: CW]), 7);
            if (up) begin
                if (e0 < 63) e0++; else begin up = 1'b0; e0--; end
            end else begin
                if (e0 > 60) e0--; else begin up = 1'b1; e0++; end
            end
            tick();
        end
    endtask

    task automatic t_restart();
        mode_sel = 2'd1;
        tick();
        check("R11 mode restart lo", 64'(dac_p[CW-1:0]), 60);
        tick();
        check("R11 then hi", 64'(dac_p[CW-1:0]), 63);
        mode_sel = 2'd2;
        tick();
        check("R11 sweep restart lo", 64'(dac_p[CW-1:0]), 60);
        mode_sel = 2'd0;
        tick();
    endtask

    task automatic t_prbs();
        logic [6:0] s;
        prbs_seed = 7'h5A;
        prbs_load = 1'b1;
        tick();
        prbs_load = 1'b0;
        src_sel   = 1'b1;
        s = 7'h5A;
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R9 prbs word", 64'(seg_en), 64'(b_seg(b_adv(s)[15:0])));
            s = b_adv(s)[22:16];
        end
    endtask

    task automatic t_zero_seed();
        prbs_seed = 7'h00;
        prbs_load = 1'b1;
        tick();
        prbs_load = 1'b0;
        tick();
        check("R10 zero seed", 64'(seg_en), 64'(b_seg(b_adv(7'h01)[15:0])));
    endtask

    initial begin
        t_reset();
        t_ext_therm();
        t_drv_off();
        t_limits();
        t_binary_common();
        t_normal();
        t_indep();
        t_sweep();
        t_restart();
        t_prbs();
        t_zero_seed();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule